// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's cache on a snooping bus and lets that processor build locks from a load-linked (LL) / store-conditional (SC) pair. An LL makes a reservation on the cache block it touches. The monitor watches write and invalidate traffic from the other caches, and any such traffic to a reserved block removes the reservation. When an SC arrives, the monitor looks for a live reservation on the block. If there is none, the SC fails at once and nothing goes onto the bus. If there is one, the monitor requests the bus. The SC succeeds only if the reservation is still live on the cycle the bus is granted.

The outcome of a race between processors is decided by the order in which they reach the bus. The first SC to reach the bus performs its write. That write appears to every other monitor as snoop traffic and clears their reservations. The losing SCs then fail locally, so they add no invalidation traffic. The table holds a few entries. When it is full, a new LL replaces the entry that was allocated longest ago. Every match is done on the block address, never on the byte address.

Top module: `resv_monitor`

## Requirements
- R1: An accepted LL (`cpuReq` with `cpuIsSc`=0 while `cpuReady`=1) records the block of `cpuAddr` as a live reservation, so that a later SC to that block can succeed.
- R2: A snoop (`snoopValid`=1) whose `snoopBlk` equals a reserved block clears that reservation, and a later SC to the block fails.
- R3: Matching uses `cpuAddr[ADDR_W-1:OFF_W]` (OFF_W = log2 of BLOCK_BYTES, 6 by default). An SC at a different byte offset in the reserved block succeeds, and a snoop to a different block leaves the reservation intact.
- R4: An SC with no live reservation on its block raises `scDone`=1 with `scOk`=0 in the cycle after acceptance, and `busReq` stays 0 for the whole SC.
- R5: An SC with a live reservation raises `busReq` in the cycle after acceptance, with `busAddr` equal to the SC address. Both hold until a cycle in which `busGrant`=1. In the next cycle `scDone`=1 and `scOk`=1.
- R6: If a snoop clears the reservation while an SC is waiting for the bus, `busReq` drops in that same cycle, a grant in that cycle does not count, and `scDone`=1 with `scOk`=0 in the next cycle.
- R7: A successful SC consumes its reservation, so a second SC to the same block with no new LL fails.
- R8: An LL to a block that is already reserved refreshes that entry rather than creating a second one. An LL to a new block goes into a free entry if there is one. If the table is full, it replaces the entry whose last LL is the oldest.
- R9: `cpuReady` is 0 while an SC waits for the bus and 1 otherwise. `scDone` is a one-cycle pulse.
- R10: After reset the table holds no reservations, `cpuReady`=1, and `busReq`=0 and `scDone`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor issues an LL or SC this cycle |
| cpuIsSc | input | 1 | 1 = store-conditional, 0 = load-linked |
| cpuAddr | input | ADDR_W | Byte address of the LL or SC |
| cpuReady | output | 1 | Monitor can accept a request |
| scDone | output | 1 | SC outcome valid (one-cycle pulse) |
| scOk | output | 1 | SC outcome: 1 = succeeded, 0 = failed |
| busReq | output | 1 | Request for the bus to perform the SC write |
| busAddr | output | ADDR_W | Address of the requested SC write |
| busGrant | input | 1 | Bus granted; with `busReq` high, the write takes place this cycle |
| snoopValid | input | 1 | Another cache writes or invalidates a block |
| snoopBlk | input | ADDR_W-OFF_W | Block address of the snooped traffic |

## Verification
The SC path is tried in four situations. With no prior LL, the SC must fail in one cycle with no bus request. After a clean LL, it must win the bus after a few cycles of waiting. It must also fail after a snoop to the same block. Finally, it must lose a race when the snoop lands while the request is pending, which shows whether liveness is checked at grant time or only at lookup time. Snoops to a neighbouring block and SCs at a different offset in the block separate block matching from full-address matching. A second SC after a success tests whether the reservation is consumed. Five distinct LLs into four entries, followed by a refresh and a further fill, show whether the victim is the entry allocated longest ago rather than a fixed slot or the most recent entry.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [0:0] {
    CTRL_IDLE = 1'b0,
    CTRL_WAIT = 1'b1
  } ctrlState_t;

  // strobes sent by the control to the reservation table
  typedef struct packed {
    logic allocEn;  // write/refresh the entry for the current LL block
    logic clearEn;  // drop the entry consumed by a winning SC
  } tableStrobe_t;

endpackage

// File: rtl/resv_table.sv
module resv_table
  import resv_pkg::*;
#(
  parameter int TAG_W   = 26,
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  tableStrobe_t       strb,
  input  logic [IDX_W-1:0]   clearIdx,
  input  logic [TAG_W-1:0]   cpuTag,
  input  logic               snoopValid,
  input  logic [TAG_W-1:0]   snoopTag,
  output logic [ENTRIES-1:0] liveVec,
  output logic               hitAny,
  output logic [IDX_W-1:0]   hitIdx
);

  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [IDX_W-1:0]   rankQ [ENTRIES];  // 0 = oldest allocation
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] cpuMatch;
  logic [ENTRIES-1:0] snoopMatch;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gCmp
      assign cpuMatch[g]   = validQ[g] && (tagQ[g] == cpuTag);
      assign snoopMatch[g] = snoopValid && validQ[g] && (tagQ[g] == snoopTag);
      assign liveVec[g]    = validQ[g] && !snoopMatch[g];
    end
  endgenerate

  // lookup for an SC: live entry holding the requested block
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (liveVec[i] && cpuMatch[i]) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  // victim for an LL: same block, else a free slot, else the oldest
  logic             sameAny;
  logic [IDX_W-1:0] sameIdx;
  logic             freeAny;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] oldIdx;
  logic [IDX_W-1:0] victimIdx;

  always_comb begin
    sameAny = 1'b0;
    sameIdx = '0;
    freeAny = 1'b0;
    freeIdx = '0;
    oldIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cpuMatch[i]) begin
        sameAny = 1'b1;
        sameIdx = IDX_W'(i);
      end
      if (!validQ[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
      if (rankQ[i] == '0) oldIdx = IDX_W'(i);
    end
    if (sameAny)      victimIdx = sameIdx;
    else if (freeAny) victimIdx = freeIdx;
    else              victimIdx = oldIdx;
  end

  logic [IDX_W-1:0] victimRank;
  assign victimRank = rankQ[victimIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]  <= '0;
        rankQ[i] <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.allocEn && victimIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          tagQ[i]   <= cpuTag;
        end else if (strb.clearEn && clearIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b0;
        end else if (snoopMatch[i]) begin
          validQ[i] <= 1'b0;
        end
        if (strb.allocEn) begin
          if (victimIdx == IDX_W'(i))      rankQ[i] <= IDX_W'(ENTRIES - 1);
          else if (rankQ[i] > victimRank)  rankQ[i] <= rankQ[i] - 1'b1;
        end
      end
    end
  end

  // R8: one block never occupies two entries
  assert_single_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cpuMatch));

  // R7: the entry consumed by a winning SC is gone next cycle
  assert_consume_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearEn && !strb.allocEn) |=> !validQ[$past(clearIdx)]);

  generate
    for (g = 0; g < ENTRIES; g++) begin : gChk
      // R2: snooped write to a reserved block removes the reservation
      assert_snoop_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
        (snoopMatch[g] && !(strb.allocEn && victimIdx == IDX_W'(g))) |=> !validQ[g]);
    end
  endgenerate

endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic               cpuIsSc,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic               hitAny,
  input  logic [IDX_W-1:0]   hitIdx,
  input  logic [ENTRIES-1:0] liveVec,
  input  logic               busGrant,
  output tableStrobe_t       strb,
  output logic [IDX_W-1:0]   clearIdx,
  output logic               cpuReady,
  output logic               busReq,
  output logic [ADDR_W-1:0]  busAddr,
  output logic               scDone,
  output logic               scOk
);

  ctrlState_t        stateQ;
  logic [IDX_W-1:0]  pendIdxQ;
  logic [ADDR_W-1:0] pendAddrQ;

  logic accept;
  logic pendLive;
  logic win;

  assign cpuReady     = (stateQ == CTRL_IDLE);
  assign accept       = cpuReq && cpuReady;
  assign pendLive     = liveVec[pendIdxQ];
  assign busReq       = (stateQ == CTRL_WAIT) && pendLive;
  assign busAddr      = pendAddrQ;
  assign win          = busReq && busGrant;
  assign strb.allocEn = accept && !cpuIsSc;
  assign strb.clearEn = win;
  assign clearIdx     = pendIdxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= CTRL_IDLE;
      pendIdxQ  <= '0;
      pendAddrQ <= '0;
      scDone    <= 1'b0;
      scOk      <= 1'b0;
    end else begin
      scDone <= 1'b0;
      case (stateQ)
        CTRL_IDLE: begin
          if (accept && cpuIsSc) begin
            if (hitAny) begin
              stateQ    <= CTRL_WAIT;
              pendIdxQ  <= hitIdx;
              pendAddrQ <= cpuAddr;
            end else begin
              scDone <= 1'b1;
              scOk   <= 1'b0;
            end
          end
        end
        CTRL_WAIT: begin
          if (win) begin
            scDone <= 1'b1;
            scOk   <= 1'b1;
            stateQ <= CTRL_IDLE;
          end else if (!pendLive) begin
            scDone <= 1'b1;
            scOk   <= 1'b0;
            stateQ <= CTRL_IDLE;
          end
        end
        default: stateQ <= CTRL_IDLE;
      endcase
    end
  end

  // R4: SC without reservation fails next cycle, never touching the bus
  assert_miss_fails_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cpuIsSc && !hitAny) |=> (scDone && !scOk && !busReq));

  // R5: a granted request reports success next cycle
  assert_grant_success_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant) |=> (scDone && scOk));

  // R5: request address holds while waiting
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |=> (!busReq || $stable(busAddr)));

  // R6: a pending SC that lost its reservation fails next cycle
  assert_lost_race_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == CTRL_WAIT && !busReq) |=> (scDone && !scOk));

  // R9: processor is held off while the bus is requested; done is a pulse
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !cpuReady);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    scDone |=> !scDone);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int ENTRIES     = 4,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int TAG_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuIsSc,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuReady,
  output logic              scDone,
  output logic              scOk,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGrant,
  input  logic              snoopValid,
  input  logic [TAG_W-1:0]  snoopBlk
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tableStrobe_t       strb;
  logic [IDX_W-1:0]   clearIdx;
  logic [ENTRIES-1:0] liveVec;
  logic               hitAny;
  logic [IDX_W-1:0]   hitIdx;

  resv_table #(
    .TAG_W  (TAG_W),
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_table (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .clearIdx  (clearIdx),
    .cpuTag    (cpuAddr[ADDR_W-1:OFF_W]),
    .snoopValid(snoopValid),
    .snoopTag  (snoopBlk),
    .liveVec   (liveVec),
    .hitAny    (hitAny),
    .hitIdx    (hitIdx)
  );

  resv_ctrl #(
    .ADDR_W (ADDR_W),
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuReq  (cpuReq),
    .cpuIsSc (cpuIsSc),
    .cpuAddr (cpuAddr),
    .hitAny  (hitAny),
    .hitIdx  (hitIdx),
    .liveVec (liveVec),
    .busGrant(busGrant),
    .strb    (strb),
    .clearIdx(clearIdx),
    .cpuReady(cpuReady),
    .busReq  (busReq),
    .busAddr (busAddr),
    .scDone  (scDone),
    .scOk    (scOk)
  );

endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int OFF_W      = 6;
  localparam int TAG_W      = ADDR_W - OFF_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReq = 1'b0;
  logic              cpuIsSc = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic              cpuReady;
  logic              scDone;
  logic              scOk;
  logic              busReq;
  logic [ADDR_W-1:0] busAddr;
  logic              busGrant = 1'b0;
  logic              snoopValid = 1'b0;
  logic [TAG_W-1:0]  snoopBlk = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  resv_monitor #(.ADDR_W(ADDR_W), .BLOCK_BYTES(64), .ENTRIES(4)) u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuIsSc(cpuIsSc), .cpuAddr(cpuAddr),
    .cpuReady(cpuReady), .scDone(scDone), .scOk(scOk), .busReq(busReq),
    .busAddr(busAddr), .busGrant(busGrant), .snoopValid(snoopValid), .snoopBlk(snoopBlk)
  );

  function automatic [TAG_W-1:0] blkOf(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic llOp(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    cpuReq = 1'b1; cpuIsSc = 1'b0; cpuAddr = a;
    @(negedge clk);
    cpuReq = 1'b0;
  endtask

  task automatic snoopOp(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    snoopValid = 1'b1; snoopBlk = blkOf(a);
    @(negedge clk);
    snoopValid = 1'b0;
  endtask

  // mode 0: expect immediate failure; 1: win after waitCyc; 2: lose to snoop after waitCyc
  task automatic scOp(input logic [ADDR_W-1:0] a, input int mode, input int waitCyc,
                      input string req);
    @(negedge clk);
    check(req, "ready before SC", cpuReady, 1);
    cpuReq = 1'b1; cpuIsSc = 1'b1; cpuAddr = a;
    @(negedge clk);
    cpuReq = 1'b0; cpuIsSc = 1'b0;
    if (mode == 0) begin
      check(req, "miss scDone", scDone, 1);
      check(req, "miss scOk", scOk, 0);
      check(req, "miss busReq", busReq, 0);
      @(negedge clk);
      check(req, "miss busReq later", busReq, 0);
      check(req, "miss scDone pulse", scDone, 0);
    end else begin
      for (int i = 0; i < waitCyc; i++) begin
        check(req, "pending busReq", busReq, 1);
        check(req, "pending busAddr", busAddr, a);
        check("R9", "ready while pending", cpuReady, 0);
        check(req, "pending no done", scDone, 0);
        @(negedge clk);
      end
      check(req, "busReq at decision", busReq, 1);
      if (mode == 1) begin
        busGrant = 1'b1;
        @(negedge clk);
        busGrant = 1'b0;
        check(req, "win scDone", scDone, 1);
        check(req, "win scOk", scOk, 1);
        check(req, "win busReq released", busReq, 0);
      end else begin
        snoopValid = 1'b1; snoopBlk = blkOf(a); busGrant = 1'b1;
        #1;
        check("R6", "busReq dropped on snoop", busReq, 0);
        @(negedge clk);
        snoopValid = 1'b0; busGrant = 1'b0;
        check("R6", "lose scDone", scDone, 1);
        check("R6", "lose scOk", scOk, 0);
      end
      check("R9", "ready after done", cpuReady, 1);
      @(negedge clk);
      check("R9", "scDone pulse", scDone, 0);
    end
  endtask

  task automatic testReset();
    check("R10", "cpuReady", cpuReady, 1);
    check("R10", "busReq", busReq, 0);
    check("R10", "scDone", scDone, 0);
    scOp(32'h0000_1000, 0, 0, "R10");     // empty table after reset
    scOp(32'h0000_2040, 0, 0, "R4");
  endtask

  task automatic testBasic();
    llOp(32'h0000_3000);
    scOp(32'h0000_3000, 1, 2, "R5");       // R1 reservation, R5 bus sequence
    scOp(32'h0000_3000, 0, 0, "R7");       // consumed
  endtask

  task automatic testSnoop();
    llOp(32'h0000_4010);
    snoopOp(32'h0000_4030);                // same block, other offset
    scOp(32'h0000_4010, 0, 0, "R2");
    llOp(32'h0000_5000);
    snoopOp(32'h0000_5040);                // neighbouring block
    scOp(32'h0000_5008, 1, 0, "R3");       // other offset in reserved block
  endtask

  task automatic testRace();
    llOp(32'h0000_6000);
    scOp(32'h0000_6000, 2, 3, "R6");
    scOp(32'h0000_6000, 0, 0, "R6");
  endtask

  task automatic testReplace();
    llOp(32'h0001_0000);  // A
    llOp(32'h0001_1000);  // B
    llOp(32'h0001_2000);  // C
    llOp(32'h0001_3000);  // D
    llOp(32'h0001_4000);  // E replaces A
    scOp(32'h0001_0000, 0, 0, "R8");
    scOp(32'h0001_1000, 1, 1, "R8");      // B frees a slot
    llOp(32'h0001_2000);  // refresh C: now youngest
    llOp(32'h0001_5000);  // F into free slot
    llOp(32'h0001_6000);  // G replaces D (oldest)
    scOp(32'h0001_3000, 0, 0, "R8");
    scOp(32'h0001_2000, 1, 0, "R8");
    scOp(32'h0001_4000, 1, 0, "R8");
    scOp(32'h0001_5000, 1, 0, "R8");
    scOp(32'h0001_6000, 1, 0, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testSnoop();
    testRace();
    testReplace();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule